// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block paces the control strobes of a multiplexed address/data memory bus for an 8-bit controller core. It divides the oscillator clock into machine cycles. Each machine cycle has twelve clocks: six states of two clocks each. In every cycle the block produces the address-latch pulse (`ale`, active high) and three active-low strobes: the code-read strobe (`psen_n`) and the data read and write strobes (`rd_n`, `wr_n`).

The core presents one request per machine cycle. The request is an opcode fetch with its address, an external data read, or an external data write. The block samples the request at the cycle boundary and classifies the cycle. A fetch goes to the external bus when `int_code_en` is low, or when the address lies above the top of on-chip code space. In all other cases the fetch is served internally, and `fetch_ext` stays low. A data cycle replaces the second address-latch pulse and both code-read pulses with a single six-clock read or write window. Clock positions below count from 0, where clock 0 is the first clock after a cycle boundary.

Top module: `ext_bus_strobe_seq`

## Requirements
- R1: In idle, internal-fetch and external-fetch cycles, `ale` is high in clocks 1–2 and 7–8 and low in all other clocks, so it rises once every six clocks.
- R2: In a data read or data write cycle, `ale` is high only in clocks 1–2. The pulse in clocks 7–8 is dropped, so the spacing between two rises becomes twelve clocks.
- R3: In an external-fetch cycle, `psen_n` is low in clocks 3–5 and 9–11, directly after each falling edge of `ale`, and high in all other clocks.
- R4: In a data cycle, `psen_n` stays high for all twelve clocks.
- R5: In internal-fetch and idle cycles, `psen_n` stays high for all twelve clocks.
- R6: In a data read cycle, `rd_n` is low in clocks 3–8 and `wr_n` stays high. In a data write cycle, `wr_n` is low in clocks 3–8 and `rd_n` stays high. In every other cycle both stay high.
- R7: A fetch is external when `int_code_en` is 0 (any address, 0x0000 included), or when `fetch_addr` > 0x0FFF. With `int_code_en` = 1 and an address of 0x0FFF or below, the fetch is internal. `fetch_ext` is high for all twelve clocks of an external-fetch cycle and low in every other cycle.
- R8: Requests are sampled only at the cycle boundary, and a change during a cycle has no effect on that cycle. Priority is read over write, and write over fetch. With no request, the cycle is idle.
- R9: While `rst_n` is low, `ale` is 0 and `psen_n`, `rd_n` and `wr_n` are 1 and `fetch_ext` is 0. This takes effect at once, also in the middle of a strobe. The first edge after release starts a new cycle at clock 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_code_en | input | 1 | 1 allows internal fetches below the code limit; 0 forces all fetches external |
| fetch_req | input | 1 | Opcode fetch requested for the next cycle |
| fetch_addr | input | 16 | Fetch address |
| data_rd_req | input | 1 | External data read requested for the next cycle |
| data_wr_req | input | 1 | External data write requested for the next cycle |
| ale | output | 1 | Address latch pulse, active high |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| fetch_ext | output | 1 | High for the whole of an external-fetch cycle |

## Verification
A slip in the clock-position counter moves every strobe edge. The first `ale` pulse after the slip shows this within six clocks. A wrong cycle classification shows up at clock 0 of the affected cycle through `fetch_ext`. It also shows up by clock 3 through a missing or extra `psen_n`, `rd_n` or `wr_n` fall. A class register that reloads in the middle of a cycle shows up in the same cycle, as a strobe pattern that switches partway through the twelve clocks.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE      = 3'd0,
    CYC_FETCH_INT = 3'd1,
    CYC_FETCH_EXT = 3'd2,
    CYC_DATA_RD   = 3'd3,
    CYC_DATA_WR   = 3'd4
  } cyc_kind_e;

  typedef struct packed {
    logic ale;
    logic psen_n;
    logic rd_n;
    logic wr_n;
    logic fetch_ext;
  } strobes_t;

  localparam strobes_t STROBES_QUIET = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1,
                                         wr_n: 1'b1, fetch_ext: 1'b0};

  // true when pos lies in [first, first+len)
  function automatic logic in_window(input int pos, input int first, input int len);
    return (pos >= first) && (pos < first + len);
  endfunction

  // cycle class from the sampled requests; data wins over fetch, read over write
  function automatic cyc_kind_e pick_kind(input logic rd, input logic wr,
                                          input logic fe, input logic goes_ext);
    if (rd)      return CYC_DATA_RD;
    else if (wr) return CYC_DATA_WR;
    else if (fe) return goes_ext ? CYC_FETCH_EXT : CYC_FETCH_INT;
    else         return CYC_IDLE;
  endfunction

endpackage

// File: rtl/ebs_cycle_timer.sv
module ebs_cycle_timer #(
  parameter int STATES         = 6,
  parameter int CLKS_PER_STATE = 2,
  localparam int CYC_CLKS      = STATES * CLKS_PER_STATE,
  localparam int CW            = $clog2(CYC_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] pos_nx,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(CYC_CLKS - 1);

  logic [CW-1:0] pos_q;

  assign wrap   = (pos_q == LAST);
  assign pos_nx = wrap ? '0 : pos_q + 1'b1;

  // parks on the last clock during reset so the first edge opens clock 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= LAST;
    else        pos_q <= pos_nx;
  end
endmodule

// File: rtl/ebs_cycle_classify.sv
module ebs_cycle_classify
  import ebs_pkg::*;
#(
  parameter int            AW           = 16,
  parameter logic [AW-1:0] INT_CODE_TOP = 16'h0FFF
) (
  input  logic          int_code_en,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  input  logic          data_rd_req,
  input  logic          data_wr_req,
  output cyc_kind_e     kind_req
);
  logic goes_ext;

  assign goes_ext = !int_code_en || (fetch_addr > INT_CODE_TOP);
  assign kind_req = pick_kind(data_rd_req, data_wr_req, fetch_req, goes_ext);
endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen
  import ebs_pkg::*;
#(
  parameter int STATES         = 6,
  parameter int CLKS_PER_STATE = 2,
  parameter int PSEN_CLKS      = 3,
  parameter int DATA_CLKS      = 6,
  localparam int CYC_CLKS      = STATES * CLKS_PER_STATE,
  localparam int CW            = $clog2(CYC_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] pos_nx,
  input  cyc_kind_e     kind_nx,
  output strobes_t      strb_q
);
  // first latch pulse opens in the second clock of the first state,
  // the second one half a machine cycle later
  localparam int ALE_A  = CLKS_PER_STATE - 1;
  localparam int ALE_B  = (STATES / 2) * CLKS_PER_STATE + ALE_A;
  localparam int CODE_A = ALE_A + CLKS_PER_STATE;
  localparam int CODE_B = ALE_B + CLKS_PER_STATE;
  localparam int DATA_A = CODE_A;

  function automatic strobes_t decode(input logic [CW-1:0] pos, input cyc_kind_e k);
    strobes_t s;
    int p;
    logic is_data;
    p       = int'(pos);
    is_data = (k == CYC_DATA_RD) || (k == CYC_DATA_WR);
    s.ale       = in_window(p, ALE_A, CLKS_PER_STATE) ||
                  (!is_data && in_window(p, ALE_B, CLKS_PER_STATE));
    s.psen_n    = !((k == CYC_FETCH_EXT) &&
                    (in_window(p, CODE_A, PSEN_CLKS) || in_window(p, CODE_B, PSEN_CLKS)));
    s.rd_n      = !((k == CYC_DATA_RD) && in_window(p, DATA_A, DATA_CLKS));
    s.wr_n      = !((k == CYC_DATA_WR) && in_window(p, DATA_A, DATA_CLKS));
    s.fetch_ext = (k == CYC_FETCH_EXT);
    return s;
  endfunction

  // outputs registered from next-state values: pin timing equals decode of current state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= STROBES_QUIET;
    else        strb_q <= decode(pos_nx, kind_nx);
  end
endmodule

// File: rtl/ext_bus_strobe_seq.sv
module ext_bus_strobe_seq
  import ebs_pkg::*;
#(
  parameter int            AW             = 16,
  parameter logic [AW-1:0] INT_CODE_TOP   = 16'h0FFF,
  parameter int            STATES         = 6,
  parameter int            CLKS_PER_STATE = 2,
  parameter int            PSEN_CLKS      = 3,
  parameter int            DATA_CLKS      = 6,
  localparam int           CYC_CLKS       = STATES * CLKS_PER_STATE,
  localparam int           CW             = $clog2(CYC_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          int_code_en,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  input  logic          data_rd_req,
  input  logic          data_wr_req,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          fetch_ext
);
  logic [CW-1:0] pos_nx;
  logic          cyc_wrap;
  cyc_kind_e     kind_req;
  cyc_kind_e     kind_q;
  cyc_kind_e     kind_nx;
  strobes_t      strb_q;

  ebs_cycle_timer #(
    .STATES(STATES), .CLKS_PER_STATE(CLKS_PER_STATE)
  ) u_tmr (
    .clk(clk), .rst_n(rst_n), .pos_nx(pos_nx), .wrap(cyc_wrap)
  );

  ebs_cycle_classify #(
    .AW(AW), .INT_CODE_TOP(INT_CODE_TOP)
  ) u_cls (
    .int_code_en(int_code_en), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .data_rd_req(data_rd_req), .data_wr_req(data_wr_req), .kind_req(kind_req)
  );

  // class is taken only at the cycle boundary and held for the whole cycle
  assign kind_nx = cyc_wrap ? kind_req : kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kind_q <= CYC_IDLE;
    else        kind_q <= kind_nx;
  end

  ebs_strobe_gen #(
    .STATES(STATES), .CLKS_PER_STATE(CLKS_PER_STATE),
    .PSEN_CLKS(PSEN_CLKS), .DATA_CLKS(DATA_CLKS)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .pos_nx(pos_nx), .kind_nx(kind_nx), .strb_q(strb_q)
  );

  assign ale       = strb_q.ale;
  assign psen_n    = strb_q.psen_n;
  assign rd_n      = strb_q.rd_n;
  assign wr_n      = strb_q.wr_n;
  assign fetch_ext = strb_q.fetch_ext;
endmodule

// File: rtl/ebs_seq_chk.sv
module ebs_seq_chk
  import ebs_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      ale,
  input logic      psen_n,
  input logic      rd_n,
  input logic      wr_n,
  input logic      fetch_ext,
  input logic      cyc_wrap,
  input cyc_kind_e kind_q
);
  logic       ale_d;
  logic       seen_rise;
  logic [4:0] since_rise;
  logic       ale_rise;

  assign ale_rise = ale && !ale_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_d      <= 1'b0;
      seen_rise  <= 1'b0;
      since_rise <= '0;
    end else begin
      ale_d <= ale;
      if (ale_rise) begin
        seen_rise  <= 1'b1;
        since_rise <= 5'd1;
      end else if (since_rise != 5'd31) begin
        since_rise <= since_rise + 5'd1;
      end
    end
  end

  AST_ALE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_rise && seen_rise) |-> (since_rise == 5'd6 || since_rise == 5'd12)); // R1
  AST_ALE_TWO_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale); // R1
  AST_ALE_NOT_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (ale && $past(ale)) |=> !ale); // R1
  AST_NO_ALE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !ale); // R2
  AST_CODE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(psen_n) |-> $fell(ale)); // R3
  AST_DATA_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == CYC_DATA_RD || kind_q == CYC_DATA_WR) |-> psen_n); // R4
  AST_INT_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ext |-> psen_n); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1); // R6
  AST_SELECT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cyc_wrap) |-> $stable(fetch_ext)); // R7
endmodule

bind ext_bus_strobe_seq ebs_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
  .fetch_ext(fetch_ext), .cyc_wrap(cyc_wrap), .kind_q(kind_q)
);

// File: tb/ext_bus_strobe_seq_bench.sv
module ext_bus_strobe_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_code_en = 1'b1;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        data_rd_req = 1'b0;
  logic        data_wr_req = 1'b0;
  logic        ale, psen_n, rd_n, wr_n, fetch_ext;

  int n_vec  = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  ext_bus_strobe_seq u_ext_bus_strobe_seq (
    .clk(clk), .rst_n(rst_n), .int_code_en(int_code_en), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .data_rd_req(data_rd_req), .data_wr_req(data_wr_req),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .fetch_ext(fetch_ext)
  );

  // vector: {rd, wr, fetch, int_code_en, mid_cycle_change, addr[15:0]}
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},  // idle
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0100},  // internal fetch
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0FFF},  // last internal address
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h1000},  // first external address
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},  // forced external at 0
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0FFF},  // forced external at limit
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF},  // top external
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},  // data read
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000},  // data write
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h2000},  // all requests: read wins
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h2000},  // write beats fetch
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000},  // read, then inputs flip mid-cycle
    {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0010},  // internal fetch, then flip
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0010}   // external fetch, then flip
  };

  task automatic check(input string tag, input string sig, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, sig, act, exp, $time);
    end
  endtask

  // bench kinds: 0 idle, 1 internal fetch, 2 external fetch, 3 read, 4 write
  function automatic int kind_of(input logic [20:0] v);
    if (v[20]) return 3;
    if (v[19]) return 4;
    if (v[18]) return (!v[17] || v[15:0] >= 16'h1000) ? 2 : 1;
    return 0;
  endfunction

  // called at a falling edge while the design shows the last clock of a cycle
  task automatic run_cycle(input logic [20:0] v, input int nclk);
    int  k;
    bit  multi;
    data_rd_req = v[20];
    data_wr_req = v[19];
    fetch_req   = v[18];
    int_code_en = v[17];
    fetch_addr  = v[15:0];
    k     = kind_of(v);
    multi = v[16] || (int'(v[20]) + int'(v[19]) + int'(v[18]) > 1);
    for (int c = 0; c < nclk; c++) begin
      bit data_c, e_ale, e_psen, e_rd, e_wr, e_fx;
      @(posedge clk);
      @(negedge clk);
      data_c = (k == 3) || (k == 4);
      e_ale  = (c == 1 || c == 2) || (!data_c && (c == 7 || c == 8));
      e_psen = !(k == 2 && ((c >= 3 && c <= 5) || c >= 9));
      e_rd   = !(k == 3 && c >= 3 && c <= 8);
      e_wr   = !(k == 4 && c >= 3 && c <= 8);
      e_fx   = (k == 2);
      check(multi ? "R8" : (data_c ? "R2" : "R1"), "ale", ale, e_ale);
      check(multi ? "R8" : (k == 2 ? "R3" : (data_c ? "R4" : "R5")), "psen_n", psen_n, e_psen);
      check(multi ? "R8" : "R6", "rd_n", rd_n, e_rd);
      check(multi ? "R8" : "R6", "wr_n", wr_n, e_wr);
      check(multi ? "R8" : "R7", "fetch_ext", fetch_ext, e_fx);
      if (v[16] && c == 4) begin
        // R8: flip every request mid-cycle; the current cycle must not change
        data_rd_req = !v[20];
        data_wr_req = !v[19];
        fetch_req   = !v[18];
        int_code_en = !v[17];
        fetch_addr  = ~v[15:0];
      end
    end
  endtask

  task automatic check_quiet(input string what);
    check("R9", {what, " ale"}, ale, 1'b0);
    check("R9", {what, " psen_n"}, psen_n, 1'b1);
    check("R9", {what, " rd_n"}, rd_n, 1'b1);
    check("R9", {what, " wr_n"}, wr_n, 1'b1);
    check("R9", {what, " fetch_ext"}, fetch_ext, 1'b0);
  endtask

  localparam logic [20:0] EXT_FETCH = {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0040};

  initial begin
    // R9: held in reset with an external fetch pending
    data_rd_req = 1'b0; data_wr_req = 1'b0; fetch_req = 1'b1; int_code_en = 1'b0;
    repeat (3) @(negedge clk);
    check_quiet("in reset");
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_cycle(VEC[i], 12);

    // R9: reset while the code strobe is low, then a clean restart
    run_cycle(EXT_FETCH, 4);
    check("R3", "psen_n before reset", psen_n, 1'b0);
    rst_n = 1'b0;
    #1;
    check_quiet("mid-strobe reset");
    repeat (3) @(negedge clk);
    check_quiet("held reset");
    rst_n = 1'b1;
    run_cycle(EXT_FETCH, 12);  // R9 restart at clock 0
    run_cycle(VEC[7], 12);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule